// File: doc/BRIEF.md
# Strided Banked Vector Load Unit

This unit carries out one vector load at a time. A single-cycle start pulse supplies a base word address, a signed stride and a vector length. Element i is read from word address base + i·stride, with the sum wrapping modulo the address width. Each request goes to one of sixteen interleaved banks, chosen by the low four address bits. The upper address bits give the word offset inside that bank.

The banks are modelled inside the unit. A bank that has just accepted an access stays occupied for a few cycles, and every access returns its word after a fixed latency. The unit issues at most one request per cycle, in element order. It stalls when the next element's bank is still occupied, so the stride decides the throughput. Returned words are presented on a register-file write port together with the element index. A done pulse follows the final write.

The modelled memory holds a fixed pattern: the word at address A reads as {A, ~A, A, ~A} (16-bit fields, most significant first).

Top module: `vload_stride_unit`

## Requirements
- R1: After reset, `busy`, `req_valid`, `wr_en` and `done` are all low.
- R2: Element i targets word address A = (base + i·stride) mod 2^16. The bank is `req_bank` = A[3:0] and the in-bank offset is `req_addr` = A[15:4].
- R3: At most one request is issued per cycle, in element order. The first request appears in the cycle after the start pulse.
- R4: No bank receives two requests less than 4 cycles apart. A stalled element is issued in the first cycle its bank is free, which gives stride 1 one element per cycle and stride 16 one element every 4 cycles.
- R5: A request issued in cycle t produces `wr_en` in cycle t+12, with `wr_idx` equal to its element number and `wr_data` = {A, ~A, A, ~A}.
- R6: The number of elements is min(vlen, 64). When vlen is 0, no request is made and `done` pulses in the cycle after start.
- R7: `done` is a one-cycle pulse in the cycle after the last write. `busy` is low in that cycle.
- R8: A start pulse that arrives while `busy` is high has no effect on the running load.
- R9: A negative stride (two's complement) walks addresses downward and wraps through zero to the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (accepted only when idle) |
| base | input | 16 | First word address |
| stride | input | 16 | Signed word stride |
| vlen | input | 7 | Element count, values above 64 treated as 64 |
| busy | output | 1 | Load in progress |
| req_valid | output | 1 | Request issued this cycle |
| req_bank | output | 4 | Bank of the request |
| req_addr | output | 12 | Word offset within the bank |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 6 | Element index being written |
| wr_data | output | 64 | Returned word |
| done | output | 1 | Load finished |

## Verification
A corrupted bank-occupancy counter shows up at once as a request issued one to three cycles too early or too late. The bench compares every issue cycle against a bank model built from the requirements. A wrong address accumulator or element counter changes `req_bank`/`req_addr` on the very next request, and twelve cycles later it changes `wr_data` or `wr_idx`. A broken latency pipeline or end condition moves the write strobes or the done pulse, and both are checked to the exact cycle.

// File: rtl/vload_stride_unit.sv
module vload_stride_unit #(
  parameter int AW    = 16,
  parameter int DW    = 64,
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  parameter int LAT   = 12,
  parameter int MAXVL = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [AW-1:0]              base,
  input  logic [AW-1:0]              stride,
  input  logic [$clog2(MAXVL+1)-1:0] vlen,
  output logic                       busy,
  output logic                       req_valid,
  output logic [$clog2(NBANK)-1:0]   req_bank,
  output logic [AW-$clog2(NBANK)-1:0] req_addr,
  output logic                       wr_en,
  output logic [$clog2(MAXVL)-1:0]   wr_idx,
  output logic [DW-1:0]              wr_data,
  output logic                       done
);
  localparam int BW = $clog2(NBANK);
  localparam int IW = $clog2(MAXVL);
  localparam int LW = $clog2(MAXVL+1);
  localparam int CW = $clog2(BUSY);

  logic          run;
  logic [AW-1:0] addr_q, stride_q;
  logic [LW-1:0] vl_q, iss_q, vl_eff;
  logic [CW-1:0] bcnt [NBANK];
  logic          pv   [LAT];
  logic [IW-1:0] pidx [LAT];
  logic [AW-1:0] paddr[LAT];

  assign vl_eff    = (vlen > LW'(MAXVL)) ? LW'(MAXVL) : vlen;
  assign busy      = run;
  assign req_bank  = addr_q[BW-1:0];
  assign req_addr  = addr_q[AW-1:BW];
  assign req_valid = run && (iss_q < vl_q) && (bcnt[req_bank] == '0);
  assign wr_en     = pv[LAT-1];
  assign wr_idx    = pidx[LAT-1];
  assign wr_data   = {(DW/(2*AW)){paddr[LAT-1], ~paddr[LAT-1]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      done     <= 1'b0;
      addr_q   <= '0;
      stride_q <= '0;
      vl_q     <= '0;
      iss_q    <= '0;
    end else begin
      done <= 1'b0;
      if (!run && start) begin
        addr_q   <= base;
        stride_q <= stride;
        vl_q     <= vl_eff;
        iss_q    <= '0;
        if (vl_eff == '0) done <= 1'b1;
        else              run  <= 1'b1;
      end else if (req_valid) begin
        addr_q <= addr_q + stride_q;
        iss_q  <= iss_q + 1'b1;
      end
      if (run && wr_en && ({1'b0, wr_idx} == LW'(vl_q - 1'b1))) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                                  bcnt[g] <= '0;
      else if (req_valid && req_bank == BW'(g))    bcnt[g] <= CW'(BUSY-1);
      else if (bcnt[g] != '0)                      bcnt[g] <= bcnt[g] - 1'b1;
    end
  end

  for (genvar k = 0; k < LAT; k++) begin : g_lat
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pv[k]    <= 1'b0;
        pidx[k]  <= '0;
        paddr[k] <= '0;
      end else if (k == 0) begin
        pv[k]    <= req_valid;
        pidx[k]  <= iss_q[IW-1:0];
        paddr[k] <= addr_q;
      end else begin
        pv[k]    <= pv[k-1];
        pidx[k]  <= pidx[k-1];
        paddr[k] <= paddr[k-1];
      end
    end
  end
endmodule

// File: rtl/vload_stride_chk.sv
module vload_stride_chk #(
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  parameter int MAXVL = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     req_valid,
  input logic [$clog2(NBANK)-1:0] req_bank,
  input logic                     wr_en,
  input logic [$clog2(MAXVL)-1:0] wr_idx,
  input logic                     done
);
  logic [7:0] age [NBANK];
  logic [7:0] outst;

  for (genvar g = 0; g < NBANK; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n)                                               age[g] <= 8'(BUSY);
      else if (req_valid && req_bank == $clog2(NBANK)'(g))      age[g] <= 8'd1;
      else if (age[g] < 8'(BUSY))                               age[g] <= age[g] + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= '0;
    else        outst <= outst + 8'(req_valid) - 8'(wr_en);
  end

  p_bank_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> age[req_bank] >= 8'(BUSY));
  p_wr_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> outst != 8'd0);
  p_wr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> wr_idx == $past(wr_idx) + 1'b1);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
endmodule

bind vload_stride_unit vload_stride_chk #(.NBANK(NBANK), .BUSY(BUSY), .MAXVL(MAXVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_valid(req_valid), .req_bank(req_bank),
  .wr_en(wr_en), .wr_idx(wr_idx), .done(done));

// File: tb/test_vload_stride_unit.sv
`timescale 1ns/1ps
module test_vload_stride_unit;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] base = 0, stride = 0;
  logic [6:0]  vlen = 0;
  logic busy, req_valid, wr_en, done;
  logic [3:0]  req_bank;
  logic [11:0] req_addr;
  logic [5:0]  wr_idx;
  logic [63:0] wr_data;

  vload_stride_unit i_vload_stride_unit (.*);

  always #4 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int iss_cyc[128], wr_cyc[128], n_iss, n_wr, done_cyc, busy_at_done;
  logic [15:0] iss_a[128];
  logic [5:0]  wr_i[128];
  logic [63:0] wr_d[128];

  always @(negedge clk) begin
    if (req_valid && n_iss < 128) begin
      iss_cyc[n_iss] = cyc; iss_a[n_iss] = {req_addr, req_bank}; n_iss++;
    end
    if (wr_en && n_wr < 128) begin
      wr_cyc[n_wr] = cyc; wr_i[n_wr] = wr_idx; wr_d[n_wr] = wr_data; n_wr++;
    end
    if (done && done_cyc < 0) begin done_cyc = cyc; busy_at_done = int'(busy); end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic test_reset();
    @(negedge clk);
    chk(!busy && !req_valid && !wr_en && !done, "R1 reset outputs",
        {busy, req_valid, wr_en, done}, 0);
  endtask

  task automatic run_load(input logic [15:0] b, input logic [15:0] s, input logic [6:0] vl,
                          input int n, input string atag, input bit disturb);
    int s0, t, wd, last_iss;
    int lastb[16];
    @(negedge clk);
    n_iss = 0; n_wr = 0; done_cyc = -1;
    base = b; stride = s; vlen = vl; start = 1; s0 = cyc;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      base = 16'h7777; stride = 16'd5; vlen = 7'd3; start = 1;
      @(negedge clk);
      start = 0;
    end
    wd = 0;
    while (done_cyc < 0 && wd < 2000) begin @(negedge clk); #1; wd++; end
    chk(done_cyc >= 0, "R7 done seen", done_cyc, 1);
    repeat (2) @(negedge clk);
    chk(n_iss == n, "R6 request count", n_iss, n);
    chk(n_wr == n, "R6 write count", n_wr, n);
    for (int k = 0; k < 16; k++) lastb[k] = -100;
    t = s0 + 1; last_iss = s0;
    for (int e = 0; e < n && e < n_iss && e < n_wr; e++) begin
      logic [15:0] a;
      a = b + 16'(e) * s;
      while (t < lastb[a[3:0]] + 4) t++;
      chk(iss_a[e] == a, atag, iss_a[e], a);
      chk(iss_cyc[e] == t, "R4 issue cycle", iss_cyc[e], t);
      chk(wr_i[e] == 6'(e), "R5 write index", wr_i[e], e);
      chk(wr_d[e] == {a, ~a, a, ~a}, "R5 write data", wr_d[e], {a, ~a, a, ~a});
      chk(wr_cyc[e] == iss_cyc[e] + 12, "R5 write latency", wr_cyc[e], iss_cyc[e] + 12);
      lastb[a[3:0]] = t; last_iss = t; t++;
    end
    if (n == 0) chk(done_cyc == s0 + 1, "R6 empty done cycle", done_cyc, s0 + 1);
    else        chk(done_cyc == last_iss + 13, "R7 done cycle", done_cyc, last_iss + 13);
    chk(busy_at_done == 0, "R7 busy low at done", busy_at_done, 0);
  endtask

  task automatic test_unit_stride();  run_load(16'h0100, 16'd1,  7'd16, 16, "R2 unit stride", 0); endtask
  task automatic test_same_bank();    run_load(16'h0203, 16'd16, 7'd8,  8,  "R4 stride 16 address", 0); endtask
  task automatic test_two_banks();    run_load(16'h0000, 16'd8,  7'd10, 10, "R4 stride 8 address", 0); endtask
  task automatic test_negative();     run_load(16'h0005, 16'hFFFD, 7'd12, 12, "R9 negative wrap", 0); endtask
  task automatic test_full_len();     run_load(16'hFFF0, 16'd3,  7'd64, 64, "R2 full length", 0); endtask
  task automatic test_clamp();        run_load(16'h1234, 16'd1,  7'd100, 64, "R6 clamp address", 0); endtask
  task automatic test_empty();        run_load(16'h4000, 16'd1,  7'd0,  0,  "R6 empty", 0); endtask
  task automatic test_busy_start();   run_load(16'h0800, 16'd2,  7'd20, 20, "R8 restart ignored", 1); endtask
  task automatic test_stride32();     run_load(16'h0011, 16'd32, 7'd5,  5,  "R3 stride 32 address", 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_unit_stride();
    test_same_bank();
    test_two_banks();
    test_negative();
    test_full_len();
    test_clamp();
    test_empty();
    test_busy_start();
    test_stride32();
    summary();
  end
endmodule